// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This core collects up to eight interrupt request lines, keeps a pending-request register, an in-service register and an interrupt mask register, and picks one pending request to forward to the processor. Input 0 has the highest priority and the last input the lowest. The processor sees a single interrupt line. It answers with a two-pulse acknowledge: the first pulse moves the winning request into service and the second presents the 3-bit level of that request.

Software controls the core through a small write port that carries three kinds of word: a mask load, an end-of-interrupt (EOI) command, and a mode word. An EOI clears either the highest-priority in-service bit or one named bit. The mode word turns on special mask mode, in which masked in-service levels stop blocking lower requests. It also turns on automatic EOI, in which the core retires the in-service bit by itself at the end of the acknowledge. Each input is set to edge or level triggering by a static configuration vector.

Top module: `prio_irq_core`

## Requirements
- R1: A write with `wr_sel_i`=2'b00 loads the mask register from `wr_data_i[NUM_IN-1:0]`. A set mask bit stops its input from raising `int_o` or being granted, and clearing the bit lets a pending request through again.
- R2: When several requests are eligible, the first acknowledge pulse grants the one with the lowest input index.
- R3: Outside special mask mode, a set in-service bit blocks every request at its own index or any higher index, while requests at lower indices still raise `int_o`.
- R4: In special mask mode, any pending request whose mask bit is clear and whose in-service bit is clear may be granted, even while a higher-priority in-service bit is set.
- R5: A write with `wr_sel_i`=2'b10 is a mode word. With bit 1 set, bit 0 becomes the special mask mode flag. With bit 1 clear, the flag is left unchanged. With bit 3 set, bit 2 becomes the automatic-EOI flag.
- R6: A write with `wr_sel_i`=2'b01 and `wr_data_i[3]`=0 is a non-specific EOI. It clears the lowest-index set in-service bit.
- R7: In special mask mode, a non-specific EOI skips in-service bits whose mask bit is set. It clears the lowest-index set in-service bit that is unmasked.
- R8: A write with `wr_sel_i`=2'b01 and `wr_data_i[3]`=1 is a specific EOI. It clears exactly the in-service bit numbered by `wr_data_i[2:0]`, whatever its priority.
- R9: On the first acknowledge pulse, exactly one in-service bit is set for the granted request. On the second pulse, the cycle that follows shows `vec_valid_o` high for one cycle with `vec_o` equal to the granted level.
- R10: With automatic EOI on, the second acknowledge pulse applies a non-specific EOI. It does not apply one when the sequence is spurious.
- R11: An edge-triggered input (`trig_level_i` bit 0) sets its request bit on a rising edge, and the bit is cleared only when that request is acknowledged. A level-triggered input (bit 1) has a request bit that follows the input one cycle later.
- R12: When no request is eligible at the first acknowledge pulse, the sequence is spurious. No in-service bit is set, and the second pulse presents level NUM_IN-1.
- R13: `int_o` is high exactly when some pending, unmasked request is not blocked by the in-service register under the current mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NUM_IN | Request inputs, bit 0 highest priority |
| trig_level_i | input | NUM_IN | Per-input trigger select: 1 level, 0 rising edge |
| wr_en_i | input | 1 | Write strobe for one command word |
| wr_sel_i | input | 2 | Word kind: 00 mask, 01 EOI, 10 mode, 11 ignored |
| wr_data_i | input | DATA_W | Command word payload |
| ack_i | input | 1 | Acknowledge pulse from the processor, one cycle per pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | One-cycle strobe after the second acknowledge pulse |
| vec_o | output | LVL_W | Level of the acknowledged request |
| isr_o | output | NUM_IN | Current in-service register |

## Verification
The bench builds the core with its default parameters: eight inputs and an 8-bit command word. With these values the spurious level 7 is the same as a real input level, so a spurious sequence can be told apart only by its unchanged in-service register. Both ends of the priority order can be reached: input 0 when masked and input 7 when it waits behind input 6 in the two mask modes. The inputs are a mix of edge and level triggering, so one run covers requests that clear on acknowledge and requests that vanish on their own before the acknowledge.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
// Package pic_pkg
// Shared command encodings and the acknowledge phase type for the
// interrupt controller core. Field positions here are the contract with
// software, so the bit numbers are fixed rather than parameters.
package pic_pkg;

    // Kind of word carried on the write port.
    typedef enum logic [1:0] {
        WSEL_MASK = 2'b00,
        WSEL_EOI  = 2'b01,
        WSEL_MODE = 2'b10,
        WSEL_RSVD = 2'b11
    } wsel_e;

    // EOI word: bit 3 selects specific, low bits carry the level.
    localparam int EOI_SPECIFIC_BIT = 3;

    // Mode word fields.
    localparam int MODE_SMM_VAL_BIT  = 0;
    localparam int MODE_SMM_EN_BIT   = 1;
    localparam int MODE_AEOI_VAL_BIT = 2;
    localparam int MODE_AEOI_EN_BIT  = 3;

    // Position inside the two-pulse acknowledge.
    typedef enum logic {
        ACK_FIRST  = 1'b0,
        ACK_SECOND = 1'b1
    } ack_phase_e;

endpackage

// File: rtl/pic_prio_enc.sv
`timescale 1ns/1ps
// Module pic_prio_enc
// Finds the lowest set index of a vector (index 0 is highest priority).
// Assumes N >= 2. Purely combinational.
module pic_prio_enc #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [LW-1:0] idx_o
);

    // Scan from the lowest priority upward so the last hit is the winner.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = LW'(i);
            end
        end
    end

endmodule

// File: rtl/pic_req_reg.sv
`timescale 1ns/1ps
// Module pic_req_reg
// Pending-request register. Each input is either level triggered (the
// bit follows the input one cycle later) or edge triggered (the bit is
// set on a rising edge and held until the acknowledge clears it).
// Assumes ack_clr_i has at most one bit set. A new rising edge in the
// same cycle as the clear wins.
module pic_req_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] lvl_mode_i,
    input  logic [N-1:0] ack_clr_i,
    output logic [N-1:0] irr_o
);

    logic [N-1:0] prev_q;
    logic [N-1:0] irr_q;
    logic [N-1:0] irr_d;

    // Per-input next-state selection by trigger mode.
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic rise;
        assign rise     = irq_i[g] & ~prev_q[g];
        assign irr_d[g] = lvl_mode_i[g] ? irq_i[g]
                                        : (rise | (irr_q[g] & ~ack_clr_i[g]));
    end

    // Register the request bits and the input history used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= irq_i;
            irr_q  <= irr_d;
        end
    end

    assign irr_o = irr_q;

endmodule

// File: rtl/pic_resolver.sv
`timescale 1ns/1ps
// Module pic_resolver
// Decides which pending request may be granted and which in-service bit
// a non-specific EOI would retire, under normal or special mask mode.
// Assumes registered inputs; the outputs are combinational.
module pic_resolver #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr_i,
    input  logic [N-1:0]  isr_i,
    input  logic [N-1:0]  imr_i,
    input  logic          smm_i,
    output logic          grant_vld_o,
    output logic [LW-1:0] grant_idx_o,
    output logic          eoi_vld_o,
    output logic [LW-1:0] eoi_idx_o
);

    logic          hi_found;
    logic [LW-1:0] hi_idx;
    logic [N-1:0]  allowed;
    logic [N-1:0]  req_ok;
    logic [N-1:0]  eoi_cand;

    // Highest-priority level currently in service (used in normal mode).
    pic_prio_enc #(.N(N)) u_isr_top (
        .vec_i   (isr_i),
        .found_o (hi_found),
        .idx_o   (hi_idx)
    );

    // Which request positions the in-service state leaves open.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (smm_i) begin
                allowed[i] = ~isr_i[i];
            end else begin
                allowed[i] = !hi_found || (LW'(i) < hi_idx);
            end
        end
    end

    // Eligible requests and the non-specific EOI candidates.
    always_comb begin
        req_ok   = irr_i & ~imr_i & allowed;
        eoi_cand = smm_i ? (isr_i & ~imr_i) : isr_i;
    end

    pic_prio_enc #(.N(N)) u_grant (
        .vec_i   (req_ok),
        .found_o (grant_vld_o),
        .idx_o   (grant_idx_o)
    );

    pic_prio_enc #(.N(N)) u_eoi (
        .vec_i   (eoi_cand),
        .found_o (eoi_vld_o),
        .idx_o   (eoi_idx_o)
    );

endmodule

// File: rtl/pic_ack_seq.sv
`timescale 1ns/1ps
// Module pic_ack_seq
// Tracks the two-pulse acknowledge. The first pulse latches the granted
// level (or the spurious level when nothing is eligible) and asks for the
// in-service bit to be set. The second pulse presents the level for one
// cycle and, in automatic-EOI mode, requests a non-specific EOI.
// Assumes each acknowledge pulse is exactly one cycle of ack_i high.
module pic_ack_seq #(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_i,
    input  logic          grant_vld_i,
    input  logic [LW-1:0] grant_idx_i,
    input  logic          aeoi_en_i,
    output logic          set_vld_o,
    output logic          auto_eoi_o,
    output logic          phase_o,
    output logic          vec_valid_o,
    output logic [LW-1:0] vec_o
);

    import pic_pkg::*;

    localparam logic [LW-1:0] SPUR_LVL = LW'(N - 1);

    ack_phase_e    phase_q;
    logic [LW-1:0] lvl_q;
    logic          spur_q;
    logic          vec_valid_q;
    logic [LW-1:0] vec_q;
    logic          first_pulse;
    logic          second_pulse;

    // Decode which pulse of the sequence is arriving.
    always_comb begin
        first_pulse  = ack_i && (phase_q == ACK_FIRST);
        second_pulse = ack_i && (phase_q == ACK_SECOND);
        set_vld_o    = first_pulse && grant_vld_i;
        auto_eoi_o   = second_pulse && aeoi_en_i && !spur_q;
    end

    // Advance the sequence, remember the level and drive the level strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= ACK_FIRST;
            lvl_q       <= '0;
            spur_q      <= 1'b0;
            vec_valid_q <= 1'b0;
            vec_q       <= '0;
        end else begin
            vec_valid_q <= second_pulse;
            if (first_pulse) begin
                phase_q <= ACK_SECOND;
                lvl_q   <= grant_vld_i ? grant_idx_i : SPUR_LVL;
                spur_q  <= !grant_vld_i;
            end else if (second_pulse) begin
                phase_q <= ACK_FIRST;
                vec_q   <= lvl_q;
            end
        end
    end

    assign phase_o     = phase_q;
    assign vec_valid_o = vec_valid_q;
    assign vec_o       = vec_q;

endmodule

// File: rtl/prio_irq_core.sv
`timescale 1ns/1ps
// Module prio_irq_core
// Eight-way (by default) fixed-priority interrupt controller core.
// Holds the mask, in-service and mode state, decodes command writes and
// combines the request register, resolver and acknowledge sequencer.
// Assumes DATA_W >= NUM_IN and DATA_W >= 4, and NUM_IN a power of two.
module prio_irq_core #(
    parameter int NUM_IN = 8,
    parameter int DATA_W = 8,
    localparam int LVL_W = $clog2(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_i,
    input  logic [NUM_IN-1:0] trig_level_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ack_i,
    output logic              int_o,
    output logic              vec_valid_o,
    output logic [LVL_W-1:0]  vec_o,
    output logic [NUM_IN-1:0] isr_o
);

    import pic_pkg::*;

    logic [NUM_IN-1:0] irr_q;
    logic [NUM_IN-1:0] isr_q;
    logic [NUM_IN-1:0] imr_q;
    logic              smm_q;
    logic              aeoi_q;

    logic              grant_vld;
    logic [LVL_W-1:0]  grant_idx;
    logic              eoi_vld;
    logic [LVL_W-1:0]  eoi_idx;
    logic              set_vld;
    logic              auto_eoi;
    logic              ack_phase;

    wsel_e             wsel;
    logic              eoi_wr;
    logic              eoi_spec;
    logic [NUM_IN-1:0] set_mask;
    logic [NUM_IN-1:0] clr_mask;

    // Pending requests with per-input trigger mode.
    pic_req_reg #(.N(NUM_IN)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_i      (irq_i),
        .lvl_mode_i (trig_level_i),
        .ack_clr_i  (set_mask),
        .irr_o      (irr_q)
    );

    // Priority decision for grants and non-specific EOIs.
    pic_resolver #(.N(NUM_IN)) u_res (
        .irr_i       (irr_q),
        .isr_i       (isr_q),
        .imr_i       (imr_q),
        .smm_i       (smm_q),
        .grant_vld_o (grant_vld),
        .grant_idx_o (grant_idx),
        .eoi_vld_o   (eoi_vld),
        .eoi_idx_o   (eoi_idx)
    );

    // Two-pulse acknowledge handshake.
    pic_ack_seq #(.N(NUM_IN)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .grant_vld_i (grant_vld),
        .grant_idx_i (grant_idx),
        .aeoi_en_i   (aeoi_q),
        .set_vld_o   (set_vld),
        .auto_eoi_o  (auto_eoi),
        .phase_o     (ack_phase),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o)
    );

    // Decode the write port and build the in-service set and clear masks.
    always_comb begin
        wsel     = wsel_e'(wr_sel_i);
        eoi_wr   = wr_en_i && (wsel == WSEL_EOI);
        eoi_spec = wr_data_i[EOI_SPECIFIC_BIT];
        set_mask = set_vld ? (NUM_IN'(1) << grant_idx) : '0;
        clr_mask = '0;
        if (eoi_wr && eoi_spec) begin
            clr_mask = clr_mask | (NUM_IN'(1) << wr_data_i[LVL_W-1:0]);
        end
        if (((eoi_wr && !eoi_spec) || auto_eoi) && eoi_vld) begin
            clr_mask = clr_mask | (NUM_IN'(1) << eoi_idx);
        end
    end

    // In-service register: acknowledge sets, EOI commands clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q | set_mask) & ~clr_mask;
        end
    end

    // Mask register and mode flags loaded from command writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q  <= '0;
            smm_q  <= 1'b0;
            aeoi_q <= 1'b0;
        end else if (wr_en_i) begin
            if (wsel == WSEL_MASK) begin
                imr_q <= wr_data_i[NUM_IN-1:0];
            end
            if (wsel == WSEL_MODE) begin
                if (wr_data_i[MODE_SMM_EN_BIT]) begin
                    smm_q <= wr_data_i[MODE_SMM_VAL_BIT];
                end
                if (wr_data_i[MODE_AEOI_EN_BIT]) begin
                    aeoi_q <= wr_data_i[MODE_AEOI_VAL_BIT];
                end
            end
        end
    end

    assign int_o = grant_vld;
    assign isr_o = isr_q;

endmodule

// File: rtl/pic_core_chk.sv
`timescale 1ns/1ps
// Module pic_core_chk
// Temporal checks on the controller core, attached by bind. Observes
// ports plus the internal mask, mode, request and grant nets.
module pic_core_chk #(
    parameter int N = 8,
    parameter int DATA_W = 8,
    localparam int LW = $clog2(N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_o,
    input logic              vec_valid_o,
    input logic [N-1:0]      isr_o,
    input logic [N-1:0]      irr_q,
    input logic [N-1:0]      imr_q,
    input logic              smm_q,
    input logic              grant_vld,
    input logic [LW-1:0]     grant_idx,
    input logic              set_vld,
    input logic              ack_i,
    input logic              ack_phase,
    input logic              wr_en_i,
    input logic [1:0]        wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i
);

    logic higher_in_service;

    // True when some in-service bit sits at or above the grant's priority.
    always_comb begin
        higher_in_service = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (isr_o[i] && (LW'(i) <= grant_idx)) begin
                higher_in_service = 1'b1;
            end
        end
    end

    assert_grant_unmasked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> !imr_q[grant_idx]);

    assert_normal_blocking_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !smm_q) |-> !higher_in_service);

    assert_smm_not_in_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && smm_q) |-> !isr_o[grant_idx]);

    assert_specific_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'b01 && wr_data_i[3] && !set_vld)
        |=> !isr_o[$past(wr_data_i[LW-1:0])]);

    assert_single_isr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_o & ~$past(isr_o)) <= 1);

    assert_vec_strobe_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    assert_spurious_keeps_isr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !ack_phase && !grant_vld && !wr_en_i) |=> $stable(isr_o));

    assert_int_needs_request_R13: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> |(irr_q & ~imr_q));

endmodule

bind prio_irq_core pic_core_chk #(.N(NUM_IN), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_o       (int_o),
    .vec_valid_o (vec_valid_o),
    .isr_o       (isr_o),
    .irr_q       (irr_q),
    .imr_q       (imr_q),
    .smm_q       (smm_q),
    .grant_vld   (grant_vld),
    .grant_idx   (grant_idx),
    .set_vld     (set_vld),
    .ack_i       (ack_i),
    .ack_phase   (ack_phase),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i)
);

// File: tb/prio_irq_core_test.sv
`timescale 1ns/1ps
// Bench for prio_irq_core: directed scenarios plus a behavioural
// reference model compared after every clock edge.
module prio_irq_core_test;

    localparam int N  = 8;
    localparam int DW = 8;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq = '0;
    logic [N-1:0]  trig = 8'h30;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'b00;
    logic [DW-1:0] wr_data = '0;
    logic          ack = 1'b0;
    logic          int_o;
    logic          vec_valid;
    logic [LW-1:0] vec;
    logic [N-1:0]  isr;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_core #(.NUM_IN(N), .DATA_W(DW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_i        (irq),
        .trig_level_i (trig),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .ack_i        (ack),
        .int_o        (int_o),
        .vec_valid_o  (vec_valid),
        .vec_o        (vec),
        .isr_o        (isr)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [N-1:0] m_irr, m_isr, m_imr, m_prev;
    bit m_smm, m_aeoi, m_phase, m_spur, m_vv;
    int m_lvl, m_vec;

    function automatic int grant_of(input logic [N-1:0] r, input logic [N-1:0] s,
                                    input logic [N-1:0] m, input bit smm);
        for (int i = 0; i < N; i++) begin
            if (!smm && s[i]) return -1;
            if (r[i] && !m[i] && !(smm && s[i])) return i;
        end
        return -1;
    endfunction

    function automatic int eoi_of(input logic [N-1:0] s, input logic [N-1:0] m, input bit smm);
        for (int i = 0; i < N; i++) begin
            if (s[i] && !(smm && m[i])) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        int g, e;
        logic [N-1:0] setm, clrm, ackclr, nirr;
        if (!rst_n) begin
            m_irr = '0; m_isr = '0; m_imr = '0; m_prev = '0;
            m_smm = 0; m_aeoi = 0; m_phase = 0; m_spur = 0; m_vv = 0;
            m_lvl = 0; m_vec = 0;
        end else begin
            g = grant_of(m_irr, m_isr, m_imr, m_smm);
            e = eoi_of(m_isr, m_imr, m_smm);
            setm = '0; clrm = '0; ackclr = '0;
            m_vv = 0;
            if (ack) begin
                if (!m_phase) begin
                    if (g >= 0) begin
                        setm[g] = 1'b1; ackclr[g] = 1'b1; m_lvl = g; m_spur = 0;
                    end else begin
                        m_lvl = N - 1; m_spur = 1;
                    end
                    m_phase = 1;
                end else begin
                    m_vv = 1; m_vec = m_lvl;
                    if (m_aeoi && !m_spur && e >= 0) clrm[e] = 1'b1;
                    m_phase = 0;
                end
            end
            if (wr_en) begin
                if (wr_sel == 2'b00) m_imr = wr_data[N-1:0];
                if (wr_sel == 2'b01) begin
                    if (wr_data[3]) clrm[wr_data[2:0]] = 1'b1;
                    else if (e >= 0) clrm[e] = 1'b1;
                end
                if (wr_sel == 2'b10) begin
                    if (wr_data[1]) m_smm = wr_data[0];
                    if (wr_data[3]) m_aeoi = wr_data[2];
                end
            end
            m_isr = (m_isr | setm) & ~clrm;
            for (int i = 0; i < N; i++) begin
                if (trig[i]) nirr[i] = irq[i];
                else nirr[i] = (irq[i] && !m_prev[i]) || (m_irr[i] && !ackclr[i]);
            end
            m_prev = irq;
            m_irr  = nirr;
        end
    end

    // Compare outputs with the model shortly after every edge.
    always @(posedge clk) begin
        bit exp_int;
        #1;
        if (rst_n && !done) begin
            exp_int = grant_of(m_irr, m_isr, m_imr, m_smm) >= 0;
            check(int_o === exp_int, "R13 model int_o", int_o, exp_int);
            check(isr === m_isr, "R9 model isr_o", isr, m_isr);
            check(vec_valid === m_vv, "R9 model vec_valid_o", vec_valid, m_vv);
            if (m_vv) check(vec === LW'(m_vec), "R9 model vec_o", vec, m_vec);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic set_irq(input logic [N-1:0] v);
        @(negedge clk); irq = v;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(int_o === 1'b0, "R13 reset int_o", int_o, 0);
        check(isr === '0, "R9 reset isr_o", isr, 0);
        check(vec_valid === 1'b0, "R9 reset vec_valid_o", vec_valid, 0);
        rst_n = 1'b1;

        // Priority, two-pulse acknowledge, blocking and EOI forms.
        set_irq(8'h0A);
        check(int_o === 1'b1, "R13 request raises int_o", int_o, 1);
        ack_pulse();
        check(isr === 8'h02, "R2 lowest index granted", isr, 8'h02);
        ack_pulse();
        check(vec_valid === 1'b1 && vec === 3'd1, "R9 level presented", {vec_valid, vec}, 4'h9);
        check(int_o === 1'b0, "R3 level 3 blocked by level 1", int_o, 0);
        wr(2'b01, 8'h00);
        check(isr === 8'h00, "R6 non-specific EOI", isr, 0);
        check(int_o === 1'b1, "R3 block lifted", int_o, 1);
        ack_pulse(); ack_pulse();
        check(isr === 8'h08, "R2 level 3 in service", isr, 8'h08);
        set_irq(8'h0E);
        check(int_o === 1'b1, "R3 higher priority passes", int_o, 1);
        ack_pulse(); ack_pulse();
        check(isr === 8'h0C, "R9 nested in service", isr, 8'h0C);
        wr(2'b01, 8'h0B);
        check(isr === 8'h04, "R8 specific EOI of lower level", isr, 8'h04);
        wr(2'b01, 8'h00);
        check(isr === 8'h00, "R6 non-specific EOI clears rest", isr, 0);
        set_irq(8'h00);

        // Special mask mode.
        wr(2'b10, 8'h03);
        set_irq(8'h40);
        ack_pulse(); ack_pulse();
        set_irq(8'hC0);
        check(int_o === 1'b1, "R4 lower level passes in special mask", int_o, 1);
        ack_pulse(); ack_pulse();
        check(isr === 8'hC0, "R4 both levels in service", isr, 8'hC0);
        wr(2'b00, 8'h40);
        wr(2'b01, 8'h00);
        check(isr === 8'h40, "R7 masked in-service bit skipped", isr, 8'h40);
        set_irq(8'h40);
        set_irq(8'hC0);
        check(int_o === 1'b1, "R4 level 7 eligible again", int_o, 1);
        wr(2'b10, 8'h00);
        check(int_o === 1'b1, "R5 set-enable clear keeps mode", int_o, 1);
        wr(2'b10, 8'h02);
        check(int_o === 1'b0, "R5 leave special mask mode", int_o, 0);
        wr(2'b00, 8'h00);
        wr(2'b01, 8'h0E);
        check(isr === 8'h00 && int_o === 1'b1, "R8 specific EOI level 6", {int_o, isr}, 9'h100);
        ack_pulse(); ack_pulse();
        wr(2'b01, 8'h00);
        set_irq(8'h00);

        // Masking.
        wr(2'b00, 8'h01);
        set_irq(8'h01);
        check(int_o === 1'b0, "R1 masked input silent", int_o, 0);
        wr(2'b00, 8'h00);
        check(int_o === 1'b1, "R1 unmask releases request", int_o, 1);
        ack_pulse(); ack_pulse();
        wr(2'b01, 8'h00);
        set_irq(8'h00);

        // Automatic EOI.
        wr(2'b10, 8'h0C);
        set_irq(8'h04);
        ack_pulse();
        check(isr === 8'h04, "R9 first pulse sets in-service", isr, 8'h04);
        ack_pulse();
        check(isr === 8'h00 && vec === 3'd2, "R10 automatic EOI", {vec, isr}, 11'h200);

        // Trigger modes.
        set_irq(8'h10);
        check(int_o === 1'b1, "R11 level input raises request", int_o, 1);
        set_irq(8'h00);
        check(int_o === 1'b0, "R11 level request follows input", int_o, 0);
        set_irq(8'h08);
        ack_pulse(); ack_pulse();
        check(int_o === 1'b0, "R11 held edge input not re-requested", int_o, 0);

        // Spurious sequence with automatic EOI on.
        wr(2'b10, 8'h08);
        set_irq(8'h0A);
        ack_pulse(); ack_pulse();
        wr(2'b10, 8'h0C);
        set_irq(8'h2A);
        set_irq(8'h0A);
        ack_pulse();
        check(isr === 8'h02, "R12 spurious sets no in-service bit", isr, 8'h02);
        ack_pulse();
        check(vec === 3'd7 && vec_valid === 1'b1, "R12 spurious level", {vec_valid, vec}, 4'hF);
        check(isr === 8'h02, "R10 no automatic EOI on spurious", isr, 8'h02);

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule